// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers four level-sensitive PCI interrupt request lines onto sixteen legacy interrupt-controller inputs. Each request line owns one byte-wide routing register. Software programs it through a small byte-addressed register port. A routing value below the output count selects a legacy output. A larger value takes that line off every output.

Internally, the block holds a level matrix with one bit for each pair of output and request line. Each legacy output is the OR of its row. On a routing write, the matrix is cleared and refilled from the present input levels using the new routes. Otherwise, each valid line refreshes only its own bit in its routed row.

A combinational query port reports, for a chosen request line, whether it is routed and to which output.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous reset, every routing register holds 0x80, and reads of offsets 0x60 (line 0), 0x61 (line 1), 0x62 (line 2) and 0x63 (line 3) return 0x80.
- R2: While reset is asserted, and on the first cycle after it, `irq_out` is all zero whatever the request levels are.
- R3: A routing value N below 16 drives output bit N from that line's level. This includes the boundary values 0 and 15.
- R4: A routing value of 16 or more (for example 0x10 or 0xE7) disables the line, so its level reaches no output.
- R5: An output is high when any of the lines routed to it is high, and it is low only when all of them are low.
- R6: A change on a routed request input appears on `irq_out` one clock edge after it is sampled.
- R7: A write to a routing register rebuilds the matrix at the same edge. The line's level moves to the new output, and the old output drops unless another line holds it.
- R8: A line that is disabled and then re-enabled contributes its current level as soon as the routing write completes.
- R9: A read of 0x60 to 0x63 returns the full stored byte, including bits 7 to 5, in the same cycle the address is presented.
- R10: The query for line `qry_pin` gives `qry_enabled`=1 with `qry_line` set to the output number when the route is below 16. Otherwise it gives `qry_enabled`=0 with `qry_line`=5'h1F.
- R11: A write to any offset outside 0x60 to 0x63 changes no route and no output, and reads of such offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | 4 | Level of each PCI interrupt request line |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wr_en | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| qry_pin | input | 2 | Request line to query |
| qry_enabled | output | 1 | Queried line is routed |
| qry_line | output | 5 | Routed output number, or 5'h1F when disabled |
| irq_out | output | 16 | Legacy interrupt-controller inputs |

## Verification
Routing writes, input level changes and reset all reach `irq_out` and the stored routes one clock edge after they are sampled. The bench therefore drives on a falling edge, lets one rising edge pass, and compares at the following falling edge. Read data and query results depend only on the stored routes and the presented address or pin, so they are compared in the same low phase in which the address or pin is applied. Every vector in the table holds its inputs for exactly one edge, so each expected output value belongs to a single sampled input set.

// File: rtl/pirq_pkg.sv
// Package: shared widths and types for the interrupt pin router.
// Assumes routing registers are one byte wide.
package pirq_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] route_byte_t;
endpackage

// File: rtl/pirq_route_regs.sv
// Routing register file: one byte per request line at consecutive offsets
// starting at BASE. Provides read data, the next-state route values used for
// rebuilding the level matrix, and the combinational route query.
// Assumes NUM_OUTS < 256 and a power-of-two NUM_PINS.
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 4,
    parameter int unsigned NUM_OUTS    = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [7:0]  BASE        = 8'h60,
    parameter logic [7:0]  RESET_ROUTE = 8'h80,
    localparam int unsigned PIN_W      = $clog2(NUM_PINS),
    localparam int unsigned OUT_W      = $clog2(NUM_OUTS),
    localparam int unsigned LINE_W     = OUT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  route_byte_t        wdata,
    output route_byte_t        rdata,
    input  logic [PIN_W-1:0]   qry_pin,
    output logic               qry_enabled,
    output logic [LINE_W-1:0]  qry_line,
    output logic               rebuild,
    output route_byte_t        route_q    [NUM_PINS],
    output route_byte_t        route_next [NUM_PINS]
);
    localparam route_byte_t       OUTS_B = route_byte_t'(NUM_OUTS);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + NUM_PINS - 1);

    logic              hit;
    logic [ADDR_W-1:0] off;
    logic [PIN_W-1:0]  idx;
    route_byte_t       qry_route;

    // Decode whether the address falls in the routing window and which line.
    always_comb begin
        hit = (addr >= BASE_A) && (addr <= LAST_A);
        off = addr - BASE_A;
        idx = off[PIN_W-1:0];
    end

    assign rebuild = wr_en && hit;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
            logic sel;
            assign sel           = rebuild && (idx == PIN_W'(p));
            assign route_next[p] = sel ? wdata : route_q[p];

            // Hold one routing byte; reset to the disabled encoding.
            always_ff @(posedge clk) begin
                if (!rst_n) route_q[p] <= RESET_ROUTE;
                else if (sel) route_q[p] <= wdata;
            end

            assert_reset_route_R1: assert property (@(posedge clk)
                !rst_n |=> (route_q[p] == RESET_ROUTE));
            assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (addr == ADDR_W'(BASE + p))) |=> (route_q[p] == $past(wdata)));
            assert_outside_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && (addr == ADDR_W'(BASE + p))) |=> $stable(route_q[p]));
        end
    endgenerate

    // Return the addressed routing byte, zero outside the window.
    always_comb begin
        rdata = '0;
        if (hit) rdata = route_q[idx];
    end

    // Answer the route query for the selected line.
    always_comb begin
        qry_route   = route_q[qry_pin];
        qry_enabled = qry_route < OUTS_B;
        qry_line    = qry_enabled ? {1'b0, qry_route[OUT_W-1:0]} : '1;
    end

    assert_query_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        qry_enabled |-> (qry_line < LINE_W'(NUM_OUTS)));
    assert_query_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_enabled |-> (qry_line == {LINE_W{1'b1}}));
endmodule

// File: rtl/pirq_level_matrix.sv
// Level matrix: one bit per (output, line) pair. On a routing write the whole
// matrix is cleared and refilled from current levels with the new routes;
// otherwise each validly routed line refreshes only its bit in its row.
// Assumes route_next equals route_q whenever rebuild is low.
module pirq_level_matrix
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned NUM_OUTS = 16,
    localparam int unsigned OUT_W   = $clog2(NUM_OUTS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_PINS-1:0]                  pin_level,
    input  logic                                 rebuild,
    input  route_byte_t                          route_q    [NUM_PINS],
    input  route_byte_t                          route_next [NUM_PINS],
    output logic [NUM_OUTS-1:0][NUM_PINS-1:0]    mat_q
);
    localparam route_byte_t OUTS_B = route_byte_t'(NUM_OUTS);

    logic [NUM_OUTS-1:0][NUM_PINS-1:0] mat_n;

    // Compute the next matrix: optional clear, then per-line bit refresh.
    always_comb begin
        mat_n = rebuild ? '0 : mat_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (route_next[p] < OUTS_B) begin
                mat_n[route_next[p][OUT_W-1:0]][p] = pin_level[p];
            end
        end
    end

    // Register the matrix; reset clears every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) mat_q <= '0;
        else        mat_q <= mat_n;
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_col
            logic [NUM_OUTS-1:0] col;
            for (genvar o = 0; o < NUM_OUTS; o++) begin : g_bit
                assign col[o] = mat_q[o][p];
            end

            assert_single_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(col));
            assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (route_q[p] >= OUTS_B) |-> (col == '0));
            assert_level_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (route_q[p] < OUTS_B))
                    |-> (mat_q[route_q[p][OUT_W-1:0]][p] == $past(pin_level[p])));
        end
    endgenerate
endmodule

// File: rtl/pirq_out_or.sv
// Output stage: each legacy output is the OR of its matrix row.
// Assumes the matrix is already registered, so outputs come straight from flops.
module pirq_out_or #(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned NUM_OUTS = 16
) (
    input  logic [NUM_OUTS-1:0][NUM_PINS-1:0] mat_q,
    output logic [NUM_OUTS-1:0]               irq_out
);
    generate
        for (genvar o = 0; o < NUM_OUTS; o++) begin : g_row
            // Reduce one row to its output level.
            assign irq_out[o] = |mat_q[o];
        end
    endgenerate
endmodule

// File: rtl/pirq_router.sv
// Top: PCI interrupt pin router. Four request lines, sixteen legacy outputs,
// byte-addressed routing registers, and a route query port.
// Assumes writes are single bytes and reads are combinational.
module pirq_router
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 4,
    parameter int unsigned NUM_OUTS    = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [7:0]  BASE        = 8'h60,
    parameter logic [7:0]  RESET_ROUTE = 8'h80,
    localparam int unsigned PIN_W      = $clog2(NUM_PINS),
    localparam int unsigned LINE_W     = $clog2(NUM_OUTS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [PIN_W-1:0]   qry_pin,
    output logic               qry_enabled,
    output logic [LINE_W-1:0]  qry_line,
    output logic [NUM_OUTS-1:0] irq_out
);
    route_byte_t                       route_q    [NUM_PINS];
    route_byte_t                       route_next [NUM_PINS];
    logic                              rebuild;
    logic [NUM_OUTS-1:0][NUM_PINS-1:0] mat_q;

    pirq_route_regs #(
        .NUM_PINS(NUM_PINS), .NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W),
        .BASE(BASE), .RESET_ROUTE(RESET_ROUTE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en),
        .wdata(reg_wdata), .rdata(reg_rdata), .qry_pin(qry_pin),
        .qry_enabled(qry_enabled), .qry_line(qry_line), .rebuild(rebuild),
        .route_q(route_q), .route_next(route_next)
    );

    pirq_level_matrix #(.NUM_PINS(NUM_PINS), .NUM_OUTS(NUM_OUTS)) u_matrix (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .rebuild(rebuild),
        .route_q(route_q), .route_next(route_next), .mat_q(mat_q)
    );

    pirq_out_or #(.NUM_PINS(NUM_PINS), .NUM_OUTS(NUM_OUTS)) u_or (
        .mat_q(mat_q), .irq_out(irq_out)
    );

    assert_out_needs_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> $past(|pin_level));
    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
endmodule

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  pin_level;
    logic [7:0]  reg_addr;
    logic        reg_wr_en;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [1:0]  qry_pin;
    logic        qry_enabled;
    logic [4:0]  qry_line;
    logic [15:0] irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pirq_router u_pirq_router (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .qry_pin(qry_pin), .qry_enabled(qry_enabled), .qry_line(qry_line),
        .irq_out(irq_out)
    );

    // {pins[3:0], wr, addr[7:0], wdata[7:0], expected irq_out[15:0]}
    localparam int NV = 13;
    localparam logic [36:0] VECS [NV] = '{
        {4'b0000, 1'b1, 8'h60, 8'h05, 16'h0000},  // R3 line0 -> 5
        {4'b0001, 1'b0, 8'h00, 8'h00, 16'h0020},  // R3 R6
        {4'b0001, 1'b1, 8'h61, 8'h05, 16'h0020},  // R5 line1 -> 5
        {4'b0011, 1'b0, 8'h00, 8'h00, 16'h0020},  // R5 both high
        {4'b0010, 1'b0, 8'h00, 8'h00, 16'h0020},  // R5 one high
        {4'b0000, 1'b0, 8'h00, 8'h00, 16'h0000},  // R6 all low
        {4'b0100, 1'b1, 8'h62, 8'h0F, 16'h8000},  // R3 boundary 15
        {4'b0100, 1'b1, 8'h62, 8'h10, 16'h0000},  // R4 boundary 16
        {4'b1100, 1'b1, 8'h63, 8'h00, 16'h0001},  // R3 boundary 0
        {4'b1100, 1'b1, 8'h63, 8'h03, 16'h0008},  // R7 move 0 -> 3
        {4'b1100, 1'b1, 8'h62, 8'h03, 16'h0008},  // R8 re-enable line2
        {4'b1000, 1'b0, 8'h00, 8'h00, 16'h0008},  // R5 shared row
        {4'b0000, 1'b1, 8'h50, 8'h07, 16'h0000}   // R11 outside write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus on the falling edge; result due one edge later.
    task automatic step(input logic [3:0] pins, input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pin_level = pins; reg_wr_en = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        check(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic qry_chk(input string req, input logic [1:0] p, input logic en, input logic [4:0] ln);
        qry_pin = p;
        #0.5;
        check(req, {26'd0, qry_enabled, qry_line}, {26'd0, en, ln});
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_level = 4'b1111; reg_addr = '0;
        reg_wr_en = 1'b0; reg_wdata = '0; qry_pin = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 in reset", 32'(irq_out), 32'h0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        pin_level = 4'b0000;
        read_chk("R1 line0", 8'h60, 8'h80);
        read_chk("R1 line1", 8'h61, 8'h80);
        read_chk("R1 line2", 8'h62, 8'h80);
        read_chk("R1 line3", 8'h63, 8'h80);
        qry_chk("R10 reset query", 2'd2, 1'b0, 5'h1F);
        @(posedge clk); @(negedge clk);
        check("R2 after reset", 32'(irq_out), 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][36:33], VECS[i][32], VECS[i][31:24], VECS[i][23:16]);
            check($sformatf("R3-table vec %0d", i), 32'(irq_out), 32'(VECS[i][15:0]));
        end

        read_chk("R9 line0", 8'h60, 8'h05);
        read_chk("R9 line1", 8'h61, 8'h05);
        read_chk("R9 line2", 8'h62, 8'h03);
        read_chk("R9 line3", 8'h63, 8'h03);
        read_chk("R11 read 0x64", 8'h64, 8'h00);
        read_chk("R11 read 0x5F", 8'h5F, 8'h00);
        qry_chk("R10 line0 enabled", 2'd0, 1'b1, 5'd5);

        step(4'b0010, 1'b1, 8'h61, 8'hE7);
        check("R4 route 0xE7", 32'(irq_out), 32'h0);
        read_chk("R9 upper bits", 8'h61, 8'hE7);
        qry_chk("R10 line1 disabled", 2'd1, 1'b0, 5'h1F);

        step(4'b1111, 1'b1, 8'h64, 8'h01);
        check("R11 outside write outputs", 32'(irq_out), 32'h0028);
        read_chk("R11 line0 kept", 8'h60, 8'h05);
        read_chk("R11 line3 kept", 8'h63, 8'h03);

        step(4'b1111, 1'b1, 8'h61, 8'h05);
        check("R8 line1 back", 32'(irq_out), 32'h0028);
        step(4'b1101, 1'b0, 8'h00, 8'h00);
        check("R5 line1 low, row held", 32'(irq_out), 32'h0028);
        step(4'b1100, 1'b0, 8'h00, 8'h00);
        check("R6 row 5 drops", 32'(irq_out), 32'h0008);

        @(negedge clk);
        rst_n = 1'b0; pin_level = 4'b1111;
        @(posedge clk); @(negedge clk);
        check("R2 mid-run reset", 32'(irq_out), 32'h0);
        read_chk("R1 mid-run reset", 8'h62, 8'h80);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R4 disabled after reset", 32'(irq_out), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule